// File: doc/BRIEF.md
# Lockable Security Control Register

This block holds a 32-bit control word behind a small word-wide register bus. Next to the control word sits a 5-bit lock register. Each lock bit freezes one group of control fields. Lock bits can be set but never cleared until reset.

A 32-bit key register guards the whole window. Writing the right key asserts the privileged control bits and keeps the window open. Writing any other value clears those bits and closes the window for good. From then on reads return zero and writes have no effect until the next reset.

The block also flags a control write that leaves the 3-bit key-enable field in a mixed state. It does this with a one-cycle pulse, so logic downstream can react. The control word itself is driven out continuously for the fabric that consumes it.

Top module: `seclock_ctrl_reg`

## Requirements
- R1: After reset, the control word reads 0x0C006000 at byte offset 0x00, and the lock register reads 0 at offset 0x04. The window is open.
- R2: A control write updates only bits 27, 26, 24 and 12:0. Bits 14:13 always read one. Bit 31 and every other bit read zero and ignore writes.
- R3: A write to the lock register ORs bits 4:0 of the data into the stored value, so a set lock bit stays set until reset. The register reads back zero-extended.
- R4: Each lock bit protects its own fields, and a protected field keeps its old value on a control write. Bit 4 protects control bit 12. Bit 3 protects bits 11:9. Bit 2 protects bit 8. Bit 1 protects bit 7. Bit 0 protects bits 6:0.
- R5: Writing 0x757BDF0D at offset 0x34 sets control bit 27 and bits 11:9, even when those bits are locked. The window stays open, and offset 0x34 reads zero.
- R6: Writing any other value at offset 0x34 clears control bit 27 and bits 11:9, and closes the window.
- R7: While the window is closed, every read returns zero and every write is dropped until reset.
- R8: An access with address bits 1:0 not both zero, or to an unmapped offset, changes nothing and reads zero.
- R9: Suppose an accepted control write leaves bits 11:9 at a value other than 000 or 111. Then the warning output is high for exactly the one cycle after the clock edge that takes the write. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ctrl_o | output | 32 | Current control word |
| win_open_o | output | 1 | High while the register window is open |
| mode_warn_o | output | 1 | Pulse flagging an inconsistent key-enable field |

## Verification
Register state, `ctrl_o` and `win_open_o` all change on the clock edge that takes a write. The bench therefore drives each write at a falling edge and checks the results at the next falling edge. `reg_rdata` is combinational, so the bench sets the address and samples a moment later in the same cycle. The warning pulse comes from a register loaded on the write edge. The bench checks it at the falling edge after the write, and checks again one cycle later that it has dropped.

// File: rtl/seclock_ctrl_reg.sv
module seclock_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter logic [31:0] KEY = 32'h757B_DF0D,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 'h04,
  parameter logic [ADDR_W-1:0] UNLOCK_OFS = 'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       ctrl_o,
  output logic              win_open_o,
  output logic              mode_warn_o
);
  localparam int LOCK_W = 5;
  localparam logic [31:0] WR_MASK = 32'h0D00_1FFF;
  localparam logic [31:0] FIXED_ONES = 32'h0000_6000;
  localparam logic [31:0] CTRL_RST = 32'h0C00_0000;
  localparam logic [31:0] KEY_BITS = 32'h0800_0E00;
  localparam logic [31:0] LOCK_MAP [LOCK_W] = '{
    32'h0000_007F, 32'h0000_0080, 32'h0000_0100, 32'h0000_0E00, 32'h0000_1000
  };

  logic [31:0]       ctrl_q, ctrl_d, prot;
  logic [LOCK_W-1:0] lock_q;
  logic              win_q, warn_q;
  logic              aligned, wr_ok, ctrl_wr, lock_wr, unlock_wr, key_ok;

  assign aligned   = (reg_addr[1:0] == 2'b00);
  assign wr_ok     = reg_we && win_q && aligned;
  assign ctrl_wr   = wr_ok && (reg_addr == CTRL_OFS);
  assign lock_wr   = wr_ok && (reg_addr == LOCK_OFS);
  assign unlock_wr = wr_ok && (reg_addr == UNLOCK_OFS);
  assign key_ok    = (reg_wdata == KEY);

  always_comb begin
    prot = '0;
    for (int i = 0; i < LOCK_W; i++)
      if (lock_q[i]) prot = prot | LOCK_MAP[i];
  end

  assign ctrl_d = (reg_wdata & WR_MASK & ~prot) | (ctrl_q & prot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      lock_q <= '0;
      win_q  <= 1'b1;
      warn_q <= 1'b0;
    end else begin
      warn_q <= ctrl_wr && (ctrl_d[11:9] != 3'b000) && (ctrl_d[11:9] != 3'b111);
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (lock_wr) lock_q <= lock_q | reg_wdata[LOCK_W-1:0];
      if (unlock_wr) begin
        ctrl_q <= key_ok ? (ctrl_q | KEY_BITS) : (ctrl_q & ~KEY_BITS);
        win_q  <= key_ok;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (win_q && aligned) begin
      if (reg_addr == CTRL_OFS) reg_rdata = ctrl_q | FIXED_ONES;
      else if (reg_addr == LOCK_OFS) reg_rdata = {{(32-LOCK_W){1'b0}}, lock_q};
    end
  end

  assign ctrl_o      = ctrl_q | FIXED_ONES;
  assign win_open_o  = win_q;
  assign mode_warn_o = warn_q;
endmodule

module seclock_ctrl_reg_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       ctrl_o,
  input logic [4:0]        lock_q,
  input logic              win_open_o,
  input logic              mode_warn_o
);
  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
  // R4
  seu_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[2] |=> (ctrl_o[8] == $past(ctrl_o[8])));
  // R4
  dbg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[0] |=> (ctrl_o[6:0] == $past(ctrl_o[6:0])));
  // R7
  win_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open_o |=> !win_open_o);
  // R7
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open_o |-> (reg_rdata == 32'h0));
  // R7
  closed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open_o |=> $stable(ctrl_o));
  // R9
  warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_warn_o |-> $past(reg_we && win_open_o && reg_addr == CTRL_OFS));
  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[14:13] == 2'b11 && ctrl_o[31] == 1'b0);
endmodule

bind seclock_ctrl_reg seclock_ctrl_reg_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .ctrl_o(ctrl_o), .lock_q(lock_q),
  .win_open_o(win_open_o), .mode_warn_o(mode_warn_o)
);

// File: tb/seclock_ctrl_reg_tb_top.sv
module seclock_ctrl_reg_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, ctrl_o;
  logic        win_open_o, mode_warn_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_ctrl;
  logic [4:0]  exp_lock;

  localparam logic [31:0] WM = 32'h0D00_1FFF;

  always #5 clk = ~clk;

  seclock_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_o(ctrl_o),
    .win_open_o(win_open_o), .mode_warn_o(mode_warn_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] prot_of(logic [4:0] l);
    logic [31:0] p = 0;
    if (l[0]) p |= 32'h7F;
    if (l[1]) p |= 32'h80;
    if (l[2]) p |= 32'h100;
    if (l[3]) p |= 32'hE00;
    if (l[4]) p |= 32'h1000;
    return p;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a; reg_we = 0;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic ctrl_wr(logic [31:0] d);
    logic [31:0] p = prot_of(exp_lock);
    logic w;
    exp_ctrl = (d & WM & ~p) | (exp_ctrl & p) | 32'h6000;
    wr(8'h00, d);
    w = (exp_ctrl[11:9] != 3'b000) && (exp_ctrl[11:9] != 3'b111);
    chk("R9 pulse", {31'b0, mode_warn_o}, {31'b0, w});
    chk("R2 ctrl_o", ctrl_o, exp_ctrl);
    @(negedge clk);
    chk("R9 one cycle", {31'b0, mode_warn_o}, 32'h0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_ctrl = 32'h0C00_6000;
    exp_lock = 0;
  endtask

  initial begin
    fork
      begin
        do_reset();
        rd_chk("R1 ctrl", 8'h00, 32'h0C00_6000);
        rd_chk("R1 lock", 8'h04, 32'h0);
        chk("R1 window", {31'b0, win_open_o}, 32'h1);

        ctrl_wr(32'hFFFF_FFFF);
        rd_chk("R2 all ones", 8'h00, 32'h0D00_7FFF);
        ctrl_wr(32'h0);
        rd_chk("R2 all zeros", 8'h00, 32'h0000_6000);
        for (int f = 0; f < 8; f++) ctrl_wr(32'hA5A5_A5A5 & ~32'hE00 | (f << 9));

        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd_chk("R8 misaligned write dropped", 8'h00, exp_ctrl);
        rd_chk("R8 misaligned read", 8'h01, 32'h0);
        rd_chk("R8 unmapped read", 8'h40, 32'h0);
        rd_chk("R5 unlock reads zero", 8'h34, 32'h0);

        for (int i = 0; i < 5; i++) begin
          exp_lock |= (5'b1 << i);
          wr(8'h04, 32'hFFFF_FFE0 | (32'h1 << i));
          rd_chk("R3 lock accumulates", 8'h04, {27'b0, exp_lock});
          wr(8'h04, 32'h0);
          rd_chk("R3 lock sticky", 8'h04, {27'b0, exp_lock});
          ctrl_wr(32'hFFFF_FFFF);
          rd_chk("R4 locked fields", 8'h00, exp_ctrl);
          ctrl_wr(32'h0);
          rd_chk("R4 locked fields", 8'h00, exp_ctrl);
        end

        wr(8'h34, 32'h757B_DF0D);
        exp_ctrl |= 32'h0800_0E00;
        rd_chk("R5 good key", 8'h00, exp_ctrl);
        chk("R5 window open", {31'b0, win_open_o}, 32'h1);

        do_reset();
        ctrl_wr(32'h0D00_1FFF);
        wr(8'h34, 32'h757B_DF0C);
        exp_ctrl &= ~32'h0800_0E00;
        chk("R6 bad key ctrl", ctrl_o, exp_ctrl);
        chk("R6 window closed", {31'b0, win_open_o}, 32'h0);
        rd_chk("R7 closed read ctrl", 8'h00, 32'h0);
        rd_chk("R7 closed read lock", 8'h04, 32'h0);
        wr(8'h00, 32'h0);
        chk("R7 write dropped", ctrl_o, exp_ctrl);
        wr(8'h34, 32'h757B_DF0D);
        chk("R7 key ignored", {31'b0, win_open_o}, 32'h0);
        chk("R7 key no effect", ctrl_o, exp_ctrl);

        do_reset();
        @(negedge clk);
        chk("R1 reopen after reset", {31'b0, win_open_o}, 32'h1);
        rd_chk("R1 ctrl after reset", 8'h00, 32'h0C00_6000);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule